// File: doc/BRIEF.md
# SPI Master Burst Shift Sequencer

This block drives a serial peripheral bus as master, one 8-bit word at a time. Software programs a control word, a total burst length and a transmit length, then sets the start bit. The sequencer pulls transmit words from an upstream queue and shifts them out on `mosi`. At the same time it assembles words from `miso` and hands them downstream. Once the transmit length is used up, the rest of the burst clocks out zero words. An external divider sets the serial clock rate through `sclk_tick`: each tick is one half period of `sclk`.

Both data paths use valid/ready handshakes. On the transmit side, a word moves on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is only raised between words, when a real data word is due. On the receive side, `rx_valid` stays high and `rx_data` holds steady until `rx_ready` is seen. The sequencer will not start the next word while the receive slot is still full, unless receive data is being discarded. While it waits for either side, `sclk` stays at its idle level and the chip selects keep their levels.

Control word fields:

| Bit(s) | Meaning |
|---|---|
| 0 | Clock phase |
| 1 | Clock polarity |
| 2 | Chip-select polarity |
| 5:4 | Chip-select index |
| 6 | Manual select |
| 7 | Manual level |
| 8 | Receive discard |
| 12 | LSB-first |
| 31 | Start / busy |

Control writes are ignored while a burst is running.

Top module: `spi_xfer_seq`

## Requirements
- R1: `sclk` rests at the clock polarity (control bit 1). With clock phase (bit 0) clear, the slave may sample `mosi` on each leading `sclk` edge and the master samples `miso` on it. With the phase set, both sides sample on the trailing edge. All four combinations move the same data.
- R2: With control bit 12 clear, the most significant bit is sent first and received first. With it set, the least significant bit goes first, in both directions.
- R3: With manual select (bit 6) set, the output at the index in bits 5:4 equals the level in bit 7. All other outputs sit at the idle level. The idle level is 1 when bit 2 is 1 (active-low selects) and 0 otherwise.
- R4: With manual select clear, the indexed output is at the active level (the inverse of bit 2) while a burst runs, and at the idle level otherwise.
- R5: With bit 8 set, no received word is presented on `rx_valid` during the burst.
- R6: Writing 1 to bit 31 while idle starts a burst. Bit 31 of `ctrl_rdata` reads 1 while the burst runs. When the burst ends it returns to 0 in the same cycle that `xfer_done` is high, and `xfer_done` is high for exactly one cycle.
- R7: A burst moves `burst_len` words. The first `tx_len` of them come from the transmit stream. The remaining words are sent as zero, and no transmit handshake is made for them.
- R8: When a data word is due and `tx_valid` is low, the sequencer waits between words. Bit 31 stays 1, `sclk` holds its idle level and the select stays active.
- R9: A burst started with `burst_len` of zero ends with `xfer_done` two clock edges after the write edge, and no serial clock edge occurs.
- R10: A control write made while a burst runs changes nothing: not the readback, not the clock idle level, and it starts no extra burst.
- R11: A received word holds `rx_valid` and `rx_data` until `rx_ready`. The next word is not shifted while that word is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 32 | Control write value |
| ctrl_rdata | output | 32 | Control readback, bit 31 = busy |
| burst_len | input | 24 | Total words in the burst, sampled at start |
| tx_len | input | 24 | Words taken from the transmit stream, sampled at start |
| sclk_tick | input | 1 | Half-period enable from the clock divider |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word accepted this cycle |
| tx_data | input | 8 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Downstream accepts received word |
| rx_data | output | 8 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| xfer_done | output | 1 | One-cycle burst-complete pulse |

## Verification
The bench runs a behavioural slave that follows the programmed phase and polarity. It checks the captured transmit word and the assembled receive word in all four modes and in both bit orders. A wrong phase would shift the data by one bit, and a wrong order would reverse it.

Several cases need directed stimulus:
- A short transmit length must produce trailing zero words with no extra handshake. A design that kept handshaking would drain the stream too far.
- A stalled transmit stream must freeze `sclk` at its idle level. A design that free-ran would clock garbage.
- A blocked receive path must hold the next word back. A design that ignored it would overwrite the pending word.
- A zero-length burst must end at once rather than hang.
- A write made mid-burst must leave the configuration and burst count alone.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CTRL_W      = 32;
  localparam int CB_CPHA     = 0;
  localparam int CB_CPOL     = 1;
  localparam int CB_CSPOL    = 2;
  localparam int CB_CSIDX_LO = 4;
  localparam int CB_MANUAL   = 6;
  localparam int CB_LEVEL    = 7;
  localparam int CB_DISCARD  = 8;
  localparam int CB_LSB      = 12;
  localparam int CB_START    = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int NUM_CS = 4,
  localparam int IW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              busy,
  input  logic              manual,
  input  logic              level,
  input  logic              active_low,
  input  logic [IW-1:0]     idx,
  output logic [NUM_CS-1:0] cs_o
);
  // Idle level equals the polarity bit; active level is its inverse.
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic hit;
    assign hit = (idx == IW'(i));
    always_comb begin
      if (!hit)        cs_o[i] = active_low;
      else if (manual) cs_o[i] = level;
      else             cs_o[i] = busy ? ~active_low : active_low;
    end
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int WORD_W = 8,
  localparam int EDGES = 2 * WORD_W,
  localparam int CW = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              step,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_next;
  logic [CW-1:0]     edge_cnt;
  logic              phase;
  logic              leading, last_edge, do_sample, do_shift;

  // Even edge numbers are leading edges (away from idle level).
  assign leading   = ~edge_cnt[0];
  assign last_edge = (edge_cnt == CW'(EDGES - 1));
  assign do_sample = step & (cpha ? ~leading : leading);
  assign do_shift  = step & (cpha ? (leading & (edge_cnt != '0))
                                  : (~leading & ~last_edge));

  always_comb begin
    rx_next = rx_sh;
    if (do_sample) begin
      if (lsb_first) rx_next = {miso, rx_sh[WORD_W-1:1]};
      else           rx_next = {rx_sh[WORD_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_cnt <= '0;
      phase    <= 1'b0;
    end else if (load) begin
      tx_sh    <= load_word;
      edge_cnt <= '0;
      phase    <= 1'b0;
    end else if (step) begin
      edge_cnt <= last_edge ? '0 : edge_cnt + CW'(1);
      phase    <= ~phase;
      rx_sh    <= rx_next;
      if (do_shift) begin
        if (lsb_first) tx_sh <= tx_sh >> 1;
        else           tx_sh <= tx_sh << 1;
      end
    end
  end

  assign sclk      = cpol ^ phase;
  assign mosi      = lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];
  assign word_done = step & last_edge;
  assign rx_word   = rx_next;
endmodule

// File: rtl/spi_burst_ctl.sv
module spi_burst_ctl
  import spi_seq_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rx_free,
  input  logic              word_done,
  output logic              tx_ready,
  output logic              load,
  output logic [WORD_W-1:0] load_word,
  output logic              shifting,
  output logic              busy,
  output logic              done
);
  seq_state_t       state;
  logic [CNT_W-1:0] rem_all, rem_tx;
  logic             need_data, word_due;

  assign need_data = (rem_tx != '0);
  assign word_due  = (state == ST_LOAD) && (rem_all != '0) && rx_free;
  assign tx_ready  = word_due && need_data;
  assign load      = word_due && (!need_data || tx_valid);
  assign load_word = need_data ? tx_data : '0;
  assign shifting  = (state == ST_SHIFT);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rem_all <= '0;
      rem_tx  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          rem_all <= burst_len;
          rem_tx  <= tx_len;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          if (rem_all == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (load) begin
            rem_all <= rem_all - CNT_W'(1);
            if (need_data) rem_tx <= rem_tx - CNT_W'(1);
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (word_done) state <= ST_LOAD;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4,
  localparam int CS_IW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              sclk_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_o,
  output logic              xfer_done
);
  logic [CTRL_W-2:0] ctrl_q;
  logic              busy, start, shifting, load, word_done, rx_free, discard;
  logic [WORD_W-1:0] load_word, rx_word;

  assign start   = ctrl_wr & ctrl_wdata[CB_START] & ~busy;
  assign discard = ctrl_q[CB_DISCARD];
  assign rx_free = discard | ~rx_valid | rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (ctrl_wr && !busy) ctrl_q <= ctrl_wdata[CTRL_W-2:0];
  end

  assign ctrl_rdata = {busy, ctrl_q};

  spi_burst_ctl #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .burst_len (burst_len),
    .tx_len    (tx_len),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_free   (rx_free),
    .word_done (word_done),
    .tx_ready  (tx_ready),
    .load      (load),
    .load_word (load_word),
    .shifting  (shifting),
    .busy      (busy),
    .done      (xfer_done)
  );

  spi_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .step      (sclk_tick & shifting),
    .cpol      (ctrl_q[CB_CPOL]),
    .cpha      (ctrl_q[CB_CPHA]),
    .lsb_first (ctrl_q[CB_LSB]),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .word_done (word_done),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (word_done && !discard) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  spi_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .busy       (busy),
    .manual     (ctrl_q[CB_MANUAL]),
    .level      (ctrl_q[CB_LEVEL]),
    .active_low (ctrl_q[CB_CSPOL]),
    .idx        (ctrl_q[CB_CSIDX_LO +: CS_IW]),
    .cs_o       (cs_o)
  );
endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_rdata,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [7:0]  rx_data,
  input logic        sclk,
  input logic [3:0]  cs_o,
  input logic        xfer_done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!ctrl_rdata[31] && $past(ctrl_rdata[31]))); // R6
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[31] |-> (sclk == ctrl_rdata[1])); // R1
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_o ^ {4{ctrl_rdata[2]}}) <= 1); // R3
  AST_TX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ctrl_rdata[31]); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R11
  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[31] && $past(ctrl_rdata[31])) |-> $stable(ctrl_rdata[30:0])); // R10
  AST_NO_RX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !ctrl_rdata[8]); // R5
endmodule

bind spi_xfer_seq spi_xfer_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_rdata (ctrl_rdata),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .sclk       (sclk),
  .cs_o       (cs_o),
  .xfer_done  (xfer_done)
);

// File: tb/spi_xfer_seq_bench.sv
module spi_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'h8000_0000;
  // {cpol, cpha, lsb_first, tx word, slave pattern}
  localparam logic [18:0] VEC [8] = '{
    {2'b00, 1'b0, 8'hA5, 8'h3C}, {2'b01, 1'b0, 8'h96, 8'hC3},
    {2'b10, 1'b0, 8'h0F, 8'h81}, {2'b11, 1'b0, 8'hF0, 8'h7E},
    {2'b00, 1'b1, 8'h01, 8'h80}, {2'b01, 1'b1, 8'hC8, 8'h13},
    {2'b10, 1'b1, 8'h5A, 8'hE4}, {2'b11, 1'b1, 8'h7F, 8'h02}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0, ctrl_rdata;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic sclk_tick = 1'b0, tx_valid, tx_ready, rx_valid, rx_ready = 1'b1;
  logic [7:0] tx_data, rx_data;
  logic sclk, mosi, miso = 1'b0, xfer_done;
  logic [3:0] cs_o;

  logic [7:0] txq [64];
  int tx_ptr = 0, tx_n = 0;
  logic tx_en = 1'b1;
  logic [7:0] rx_log [64], mosi_log [64];
  int n_rx = 0, n_mosi = 0, n_done = 0, n_hs = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] pat_m = '0, cap = '0;
  int arm_seq = 0, arm_seen = 0, mi = 0, cbits = 0;
  logic prev_sclk = 1'b0;

  assign tx_valid = tx_en && (tx_ptr < tx_n);
  assign tx_data  = txq[tx_ptr];

  spi_xfer_seq u_spi_xfer_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .burst_len(burst_len), .tx_len(tx_len),
    .sclk_tick(sclk_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_o(cs_o), .xfer_done(xfer_done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) sclk_tick <= ~sclk_tick;

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin tx_ptr <= tx_ptr + 1; n_hs <= n_hs + 1; end
    if (rx_valid && rx_ready) begin rx_log[n_rx] <= rx_data; n_rx <= n_rx + 1; end
    if (xfer_done) n_done <= n_done + 1;
  end

  // Behavioural slave: captures mosi MSB-first, sends pat_m MSB-first.
  always @(negedge clk) begin
    logic cpol_m, cpha_m, lead, trail;
    cpol_m = ctrl_rdata[1];
    cpha_m = ctrl_rdata[0];
    lead  = (sclk != cpol_m) && (prev_sclk == cpol_m);
    trail = (sclk == cpol_m) && (prev_sclk != cpol_m);
    if (arm_seq != arm_seen) begin
      arm_seen = arm_seq; mi = 0; cbits = 0; miso = pat_m[7];
    end else if (ctrl_rdata[31]) begin
      if ((lead && !cpha_m) || (trail && cpha_m)) begin
        cap = {cap[6:0], mosi};
        cbits++;
        if (cbits == 8) begin mosi_log[n_mosi] = cap; n_mosi++; cbits = 0; end
      end
      if (lead && cpha_m) begin miso = pat_m[7 - mi]; mi = (mi + 1) % 8; end
      if (trail && !cpha_m) begin mi = (mi + 1) % 8; miso = pat_m[7 - mi]; end
    end
    prev_sclk = sclk;
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    txq[tx_n] = b; tx_n++;
  endtask

  task automatic wait_done(input int base);
    int k = 0;
    while (n_done <= base && k < 5000) begin @(negedge clk); k++; end
    if (k >= 5000) chk("R6 burst timeout", 0, 1);
  endtask

  task automatic launch(input logic [31:0] cfg, input logic [7:0] pat,
                        input int blen, input int tlen);
    burst_len = 24'(blen); tx_len = 24'(tlen); pat_m = pat;
    wr_ctrl(cfg);
    arm_seq++;
    wr_ctrl(cfg | START);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk("watchdog", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b0, m0, r0, h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R6 reset readback", ctrl_rdata, 0);
    chk("R4 reset selects", 32'(cs_o), 0);
    chk("R1 reset sclk", 32'(sclk), 0);
    chk("R11 reset rx_valid", 32'(rx_valid), 0);
    chk("R6 reset done", 32'(xfer_done), 0);

    // Table: modes and bit orders (R1, R2)
    for (int v = 0; v < 8; v++) begin
      logic [18:0] e;
      logic [31:0] cfg;
      e = VEC[v];
      cfg = (32'(e[18]) << 1) | 32'(e[17]) | (32'(e[16]) << 12);
      b0 = n_done; m0 = n_mosi; r0 = n_rx;
      push(e[15:8]);
      launch(cfg, e[7:0], 1, 1);
      wait_done(b0);
      repeat (3) @(negedge clk);
      chk("R1 R2 mosi word", 32'(mosi_log[m0]), 32'(e[16] ? rev8(e[15:8]) : e[15:8]));
      chk("R1 R2 rx word", 32'(rx_log[r0]), 32'(e[16] ? rev8(e[7:0]) : e[7:0]));
      chk("R6 one done", 32'(n_done - b0), 1);
      chk("R1 idle level", 32'(sclk), 32'(e[18]));
    end

    // R7: short transmit length, zero fill
    b0 = n_done; m0 = n_mosi; r0 = n_rx; h0 = n_hs;
    push(8'hE7); push(8'h99);
    launch(32'h0, 8'h00, 3, 1);
    wait_done(b0);
    repeat (3) @(negedge clk);
    chk("R7 word0", 32'(mosi_log[m0]), 32'hE7);
    chk("R7 word1 zero", 32'(mosi_log[m0+1]), 0);
    chk("R7 word2 zero", 32'(mosi_log[m0+2]), 0);
    chk("R7 handshakes", 32'(n_hs - h0), 1);
    chk("R7 rx count", 32'(n_rx - r0), 3);
    tx_n = tx_ptr;  // drop unused word

    // R5: discard mode
    b0 = n_done; m0 = n_mosi; r0 = n_rx;
    push(8'h12); push(8'h34);
    launch(32'h100, 8'hFF, 2, 2);
    wait_done(b0);
    repeat (3) @(negedge clk);
    chk("R5 no rx words", 32'(n_rx - r0), 0);
    chk("R5 tx still sent", 32'(mosi_log[m0+1]), 32'h34);

    // R9 and R6: zero-length burst timing
    burst_len = '0; tx_len = '0;
    wr_ctrl(32'h0);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = START;
    @(negedge clk); ctrl_wr = 1'b0;
    chk("R6 busy readback", 32'(ctrl_rdata[31]), 1);
    @(negedge clk);
    chk("R9 done pulse", 32'(xfer_done), 1);
    chk("R6 busy cleared", 32'(ctrl_rdata[31]), 0);
    @(negedge clk);
    chk("R6 done one cycle", 32'(xfer_done), 0);

    // R3: manual select
    wr_ctrl(32'h64);      // manual, level 0, active low, index 2
    chk("R3 manual low", 32'(cs_o), 32'hB);
    wr_ctrl(32'hE4);      // level 1
    chk("R3 manual high", 32'(cs_o), 32'hF);
    wr_ctrl(32'hF0);      // active high, index 3, level 1
    chk("R3 manual index3", 32'(cs_o), 32'h8);

    // R4 and R8: auto select with a stalled transmit stream
    tx_en = 1'b0;
    b0 = n_done; m0 = n_mosi; h0 = n_hs;
    push(8'hC1); push(8'h3E);
    launch(32'h10, 8'h00, 2, 2);
    repeat (40) @(negedge clk);
    chk("R8 still busy", 32'(ctrl_rdata[31]), 1);
    chk("R8 sclk idle", 32'(sclk), 0);
    chk("R4 select active", 32'(cs_o), 32'h2);
    chk("R8 no handshake", 32'(n_hs - h0), 0);
    tx_en = 1'b1;
    wait_done(b0);
    repeat (3) @(negedge clk);
    chk("R8 words after stall", {16'h0, mosi_log[m0], mosi_log[m0+1]}, 32'hC13E);
    chk("R4 select released", 32'(cs_o), 0);

    // R10: control write during a burst
    b0 = n_done;
    push(8'h3C);
    launch(32'h0, 8'h00, 1, 1);
    wr_ctrl(START | 32'h3);
    chk("R10 readback unchanged", 32'(ctrl_rdata[30:0]), 0);
    wait_done(b0);
    repeat (60) @(negedge clk);
    chk("R10 single burst", 32'(n_done - b0), 1);
    chk("R10 idle level kept", 32'(sclk), 0);

    // R11: receive back-pressure
    rx_ready = 1'b0;
    b0 = n_done; m0 = n_mosi; r0 = n_rx;
    push(8'h11); push(8'h22);
    launch(32'h0, 8'h5A, 2, 2);
    repeat (200) @(negedge clk);
    chk("R11 rx held", 32'(rx_valid), 1);
    chk("R11 rx data", 32'(rx_data), 32'h5A);
    chk("R11 second word waits", 32'(n_mosi - m0), 1);
    rx_ready = 1'b1;
    wait_done(b0);
    repeat (3) @(negedge clk);
    chk("R11 both words", 32'(n_rx - r0), 2);
    chk("R11 second value", 32'(rx_log[r0+1]), 32'h5A);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule